// File: doc/BRIEF.md
# Translation Fault Resolution Control Register

This block is the per-slice control word through which privileged software settles a memory transaction that stalled on an address-translation fault. A single full-width write selects one of three resolutions: reissue the stalled transaction, drop it and report an abort to the accelerator, or fail it with an address-error response. The chosen resolution becomes a pending request toward the command-queue engine. It stays visible in the readback until the engine pulses completion. The bit then clears by itself, and a one-cycle pulse tells the companion fault-status register to drop its translation-fault bit.

The same word carries a write-only acknowledge field. Writing a one to it produces a one-cycle pulse that clears the three non-translation error flags in the companion status register: engine error, accelerator error and context warning. Accesses that are not privileged or that do not enable every byte lane are ignored. Reserved bits and the acknowledge bit always read as zero.

Top module: `tfault_ctl_reg`

## Requirements
- R1: An access is accepted only when `priv` is 1 and all eight bits of `be` are 1. A rejected write changes no state and produces no pulse, and a rejected read returns all zeros on `rdata`.
- R2: Field positions use MSB-0 numbering on the 64-bit word, which is LSB-0 index 63 minus the MSB-0 number. Acknowledge is MSB-0 bit 28 (index 35), abort-and-continue is bit 29 (index 34), address error is bit 30 (index 33) and reissue is bit 31 (index 32). An accepted read shows a 1 only at the position of the pending resolution. All other bits, including acknowledge and the reserved bits, read 0.
- R3: When one accepted write sets more than one resolution bit, only one is taken. Address error wins over abort, and abort wins over reissue.
- R4: A resolution write is taken only while `fault_pend` is 1 and no resolution is already pending. Otherwise its resolution bits are discarded.
- R5: While a resolution is pending, `req_valid` is 1 and `req_kind` carries it, encoded as 01 reissue, 10 abort, 11 address error. A pending reissue drives `req_valid` only while `queue_normal` is 1, and it is held pending otherwise.
- R6: When `eng_done` is 1 while `req_valid` is 1, the pending resolution clears at that clock edge and `clr_xlat_stat` is 1 for exactly the following cycle. `eng_done` while `req_valid` is 0 has no effect.
- R7: A later accepted write with zeros in the resolution bits does not cancel a pending resolution.
- R8: An accepted write with the acknowledge bit set drives `clr_nonxlat` to all ones for exactly the next cycle. This happens whether or not a fault is pending.
- R9: With `rst_n` low at a clock edge, the pending resolution and both pulse outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| priv | input | 1 | Access is privileged |
| be | input | 8 | Byte-lane enables of the access |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational from the current state |
| fault_pend | input | 1 | A translation fault is stalling the slice |
| queue_normal | input | 1 | Command queue is in its normal operational state |
| eng_done | input | 1 | Engine completion pulse for the offered request |
| req_valid | output | 1 | Resolution request offered to the engine |
| req_kind | output | 2 | Resolution kind: 01 reissue, 10 abort, 11 address error |
| clr_xlat_stat | output | 1 | One-cycle clear of the translation-fault status bit |
| clr_nonxlat | output | 3 | One-cycle clear of the non-translation error flags |

## Verification
The assertions assume that `eng_done` is a single-cycle pulse that the engine raises only in answer to an offered request. They also assume that `queue_normal` and `fault_pend` are ordinary levels that change only between clock edges. The stimulus drives every input on the falling edge and pulses `eng_done` for one cycle, though some pulses are deliberately sent while no request is offered, to check that they are ignored. The sweep covers all sixteen combinations of the four field bits against both values of `fault_pend` and `queue_normal`. Each combination is brought back to the idle state through a completion before the next case starts.

// File: rtl/tfc_pkg.sv
// Package: shared types and helpers for the translation fault resolution register.
// Assumes fields are documented in MSB-0 numbering on a DATA_W-bit word.
package tfc_pkg;

    // Resolution held pending; the encoding is also the req_kind port value
    typedef enum logic [1:0] {
        RES_NONE     = 2'b00,
        RES_REISSUE  = 2'b01,
        RES_ABORT    = 2'b10,
        RES_ADDR_ERR = 2'b11
    } res_kind_e;

    // Convert an MSB-0 bit number into an LSB-0 vector index
    function automatic int unsigned msb0_to_idx(input int unsigned width,
                                                input int unsigned msb0);
        return width - 1 - msb0;
    endfunction

endpackage

// File: rtl/tfc_access_qual.sv
// Module: tfc_access_qual
// Decides whether a register access counts. Only privileged accesses with
// every byte lane enabled are accepted; anything else is ignored.
// Assumes be has one bit per byte of the data word.
module tfc_access_qual #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic            priv,
    input  logic [BE_W-1:0] be,
    output logic            wr_ok,
    output logic            rd_ok
);

    logic full_word;

    // Purpose: detect a full-width access from the byte enables
    always_comb begin
        full_word = &be;
    end

    // Purpose: qualify the read and write strobes with privilege and width
    always_comb begin
        wr_ok = wr_en && priv && full_word;
        rd_ok = rd_en && priv && full_word;
    end

endmodule

// File: rtl/tfc_cmd_decode.sv
// Module: tfc_cmd_decode
// Extracts the resolution and acknowledge fields from an accepted write and
// picks a single resolution by fixed priority (address error, abort, reissue).
// Assumes wr_ok is already qualified; drops resolutions unless a fault is
// pending and the tracker is idle.
module tfc_cmd_decode
    import tfc_pkg::*;
#(
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned POS_ACK    = 28,
    parameter int unsigned POS_ABORT  = 29,
    parameter int unsigned POS_ADDERR = 30,
    parameter int unsigned POS_REISS  = 31
) (
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fault_pend,
    input  logic              pend_busy,
    output res_kind_e         new_kind,
    output logic              ack_hit
);

    localparam int unsigned IDX_ACK    = msb0_to_idx(DATA_W, POS_ACK);
    localparam int unsigned IDX_ABORT  = msb0_to_idx(DATA_W, POS_ABORT);
    localparam int unsigned IDX_ADDERR = msb0_to_idx(DATA_W, POS_ADDERR);
    localparam int unsigned IDX_REISS  = msb0_to_idx(DATA_W, POS_REISS);

    logic f_abort, f_adderr, f_reiss, take;

    // Purpose: pull the resolution field bits out of the written word
    always_comb begin
        f_abort  = wdata[IDX_ABORT];
        f_adderr = wdata[IDX_ADDERR];
        f_reiss  = wdata[IDX_REISS];
        take     = wr_ok && fault_pend && !pend_busy;
    end

    // Purpose: fixed-priority choice of one resolution for this write
    always_comb begin
        new_kind = RES_NONE;
        if (take) begin
            if (f_adderr)     new_kind = RES_ADDR_ERR;
            else if (f_abort) new_kind = RES_ABORT;
            else if (f_reiss) new_kind = RES_REISSUE;
        end
    end

    // Purpose: acknowledge acts on any accepted write, fault or not
    always_comb begin
        ack_hit = wr_ok && wdata[IDX_ACK];
    end

endmodule

// File: rtl/tfc_pend_track.sv
// Module: tfc_pend_track
// Holds the one pending resolution, offers it to the command-queue engine and
// self-clears on the engine's completion pulse, then pulses the status clear.
// Assumes eng_done is a one-cycle pulse answering an offered request.
module tfc_pend_track
    import tfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  res_kind_e new_kind,
    input  logic      queue_normal,
    input  logic      eng_done,
    output res_kind_e pend_kind,
    output logic      req_valid,
    output logic      clr_xlat_stat
);

    logic finish;

    // Purpose: offer the request; reissue waits for a normal queue
    always_comb begin
        req_valid = (pend_kind != RES_NONE) &&
                    ((pend_kind != RES_REISSUE) || queue_normal);
        finish    = req_valid && eng_done;
    end

    // Purpose: pending state and status-clear pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_kind     <= RES_NONE;
            clr_xlat_stat <= 1'b0;
        end else begin
            clr_xlat_stat <= finish;
            if (finish)
                pend_kind <= RES_NONE;
            else if (pend_kind == RES_NONE && new_kind != RES_NONE)
                pend_kind <= new_kind;
        end
    end

    AST_RESTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pend_kind == RES_REISSUE) |-> queue_normal); // R5
    AST_CLR_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_xlat_stat |-> $past(eng_done && req_valid)); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && req_valid) |=> (pend_kind == RES_NONE && clr_xlat_stat)); // R6
    AST_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind != RES_NONE && !(eng_done && req_valid)) |=> $stable(pend_kind)); // R7

endmodule

// File: rtl/tfc_ack_pulse.sv
// Module: tfc_ack_pulse
// Turns an accepted acknowledge write into a one-cycle clear of every
// non-translation error flag in the companion status register.
// Assumes ack_hit is high for a single cycle per accepted write.
module tfc_ack_pulse #(
    parameter int unsigned FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_hit,
    output logic [FLAG_W-1:0] clr_nonxlat
);

    // Purpose: register the clear so it lands one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) clr_nonxlat <= '0;
        else        clr_nonxlat <= {FLAG_W{ack_hit}};
    end

    AST_ACK_ALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_nonxlat != '0) |-> (clr_nonxlat == {FLAG_W{1'b1}})); // R8
    AST_ACK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_nonxlat != '0) |-> $past(ack_hit)); // R8

endmodule

// File: rtl/tfault_ctl_reg.sv
// Module: tfault_ctl_reg (top)
// Per-slice translation fault resolution control register. Qualifies the
// access, decodes one resolution, tracks it to completion and builds readback.
// Assumes a single full-width privileged access per operation.
module tfault_ctl_reg
    import tfc_pkg::*;
#(
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned FLAG_W     = 3,
    parameter int unsigned POS_ACK    = 28,
    parameter int unsigned POS_ABORT  = 29,
    parameter int unsigned POS_ADDERR = 30,
    parameter int unsigned POS_REISS  = 31,
    localparam int unsigned BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              priv,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fault_pend,
    input  logic              queue_normal,
    input  logic              eng_done,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic              clr_xlat_stat,
    output logic [FLAG_W-1:0] clr_nonxlat
);

    localparam int unsigned IDX_ABORT  = msb0_to_idx(DATA_W, POS_ABORT);
    localparam int unsigned IDX_ADDERR = msb0_to_idx(DATA_W, POS_ADDERR);
    localparam int unsigned IDX_REISS  = msb0_to_idx(DATA_W, POS_REISS);
    localparam int unsigned IDX_ACK    = msb0_to_idx(DATA_W, POS_ACK);

    logic      wr_ok, rd_ok, ack_hit;
    res_kind_e new_kind, pend_kind;
    logic      unused_wdata;
    logic [DATA_W-1:0] image;

    tfc_access_qual #(.DATA_W(DATA_W)) u_qual (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .priv  (priv),
        .be    (be),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok)
    );

    tfc_cmd_decode #(
        .DATA_W     (DATA_W),
        .POS_ACK    (POS_ACK),
        .POS_ABORT  (POS_ABORT),
        .POS_ADDERR (POS_ADDERR),
        .POS_REISS  (POS_REISS)
    ) u_dec (
        .wr_ok      (wr_ok),
        .wdata      (wdata),
        .fault_pend (fault_pend),
        .pend_busy  (pend_kind != RES_NONE),
        .new_kind   (new_kind),
        .ack_hit    (ack_hit)
    );

    tfc_pend_track u_pend (
        .clk           (clk),
        .rst_n         (rst_n),
        .new_kind      (new_kind),
        .queue_normal  (queue_normal),
        .eng_done      (eng_done),
        .pend_kind     (pend_kind),
        .req_valid     (req_valid),
        .clr_xlat_stat (clr_xlat_stat)
    );

    tfc_ack_pulse #(.FLAG_W(FLAG_W)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_hit     (ack_hit),
        .clr_nonxlat (clr_nonxlat)
    );

    // Purpose: reserved write bits have no destination
    always_comb begin
        unused_wdata = ^wdata;
    end

    // Purpose: drive the request kind seen by the engine
    always_comb begin
        req_kind = req_valid ? pend_kind : RES_NONE;
    end

    // Purpose: readback image with only the pending resolution bit set
    always_comb begin
        image = '0;
        unique case (pend_kind)
            RES_REISSUE:  image[IDX_REISS]  = 1'b1;
            RES_ABORT:    image[IDX_ABORT]  = 1'b1;
            RES_ADDR_ERR: image[IDX_ADDERR] = 1'b1;
            default:      image = '0;
        endcase
        rdata = rd_ok ? image : '0;
    end

    AST_ONE_READ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rdata[IDX_REISS], rdata[IDX_ABORT], rdata[IDX_ADDERR]})); // R3
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[IDX_ACK] == 1'b0); // R2
    AST_WRITE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_kind == RES_NONE && !fault_pend) |=> pend_kind == RES_NONE); // R4

endmodule

// File: tb/sim_tfault_ctl_reg.sv
module sim_tfault_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, priv = 1'b1;
    logic [7:0]  be = 8'hFF;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        fault_pend = 1'b0, queue_normal = 1'b1, eng_done = 1'b0;
    logic        req_valid, clr_xlat_stat;
    logic [1:0]  req_kind;
    logic [2:0]  clr_nonxlat;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tfault_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .priv(priv),
        .be(be), .wdata(wdata), .rdata(rdata), .fault_pend(fault_pend),
        .queue_normal(queue_normal), .eng_done(eng_done), .req_valid(req_valid),
        .req_kind(req_kind), .clr_xlat_stat(clr_xlat_stat), .clr_nonxlat(clr_nonxlat)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Field word: A idx35, C idx34, AE idx33, R idx32, reserved filled with junk
    function automatic logic [63:0] mk(input bit a, input bit c, input bit ae,
                                       input bit r, input logic [63:0] junk);
        return (junk & ~(64'hF << 32)) | ({60'd0, a, c, ae, r} << 32);
    endfunction

    function automatic logic [63:0] img(input int k);
        case (k)
            1: return 64'h1 << 32;
            2: return 64'h1 << 34;
            3: return 64'h1 << 33;
            default: return 64'h0;
        endcase
    endfunction

    task automatic do_write(input logic [63:0] d, input logic [7:0] b, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wdata = d; be = b; priv = p;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; be = 8'hFF; priv = 1'b1;
    endtask

    task automatic do_read(input logic [7:0] b, input logic p, output logic [63:0] q);
        rd_en = 1'b1; be = b; priv = p;
        #1 q = rdata;
        rd_en = 1'b0; be = 8'hFF; priv = 1'b1;
    endtask

    task automatic pulse_done;
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic finish_report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_report();
    end

    initial begin
        logic [63:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'hFF, 1'b1, q);
        chk(q == 0 && !req_valid && !clr_xlat_stat && clr_nonxlat == 0, "R9 reset state", q, 0);

        // Full sweep: field bits x fault_pend x queue_normal
        for (int v = 0; v < 64; v++) begin
            bit a, c, ae, r, fp, qn;
            int k;
            logic [63:0] junk;
            {fp, qn, a, c, ae, r} = v[5:0];
            junk = {v[7:0], 56'hA5C3_0F96_7E12_B4} ^ {8{v[7:0]}};
            k = !fp ? 0 : ae ? 3 : c ? 2 : r ? 1 : 0;
            fault_pend = fp; queue_normal = qn;
            do_write(mk(a, c, ae, r, junk), 8'hFF, 1'b1);
            chk(clr_nonxlat == (a ? 3'b111 : 3'b000), "R8 ack pulse", clr_nonxlat, a ? 7 : 0);
            do_read(8'hFF, 1'b1, q);
            chk(q == img(k), "R2 R3 R4 readback", q, img(k));
            chk(req_valid == (k != 0 && (k != 1 || qn)), "R5 req_valid", req_valid,
                (k != 0 && (k != 1 || qn)));
            @(negedge clk);
            chk(clr_nonxlat == 0, "R8 pulse one cycle", clr_nonxlat, 0);
            if (k != 0) begin
                if (req_valid)
                    chk(req_kind == k[1:0], "R5 req_kind", req_kind, k);
                do_write(mk(1'b0, 1'b0, 1'b0, 1'b0, junk), 8'hFF, 1'b1);
                do_read(8'hFF, 1'b1, q);
                chk(q == img(k), "R7 zero write keeps pending", q, img(k));
                do_write(mk(1'b0, 1'b1, 1'b1, 1'b1, 64'h0), 8'hFF, 1'b1);
                do_read(8'hFF, 1'b1, q);
                chk(q == img(k), "R4 write while pending ignored", q, img(k));
                if (k == 1 && !qn) begin
                    pulse_done();
                    do_read(8'hFF, 1'b1, q);
                    chk(q == img(1) && !clr_xlat_stat, "R6 done without request", q, img(1));
                    queue_normal = 1'b1;
                    #1 chk(req_valid && req_kind == 2'b01, "R5 reissue released", req_kind, 1);
                end
                pulse_done();
                do_read(8'hFF, 1'b1, q);
                chk(q == 0 && clr_xlat_stat && !req_valid, "R6 completion clears", q, 0);
                @(negedge clk);
                chk(!clr_xlat_stat, "R6 clear one cycle", clr_xlat_stat, 0);
            end else begin
                pulse_done();
                chk(!clr_xlat_stat, "R6 idle done ignored", clr_xlat_stat, 0);
            end
        end

        // Access qualification: missing byte lanes or non-privileged
        fault_pend = 1'b1; queue_normal = 1'b1;
        for (int lane = 0; lane < 9; lane++) begin
            logic [7:0] b;
            logic p;
            b = (lane < 8) ? ~(8'h1 << lane) : 8'hFF;
            p = (lane < 8);
            do_write(mk(1'b1, 1'b1, 1'b0, 1'b0, 64'h0), b, p);
            chk(clr_nonxlat == 0, "R1 rejected ack", clr_nonxlat, 0);
            do_read(8'hFF, 1'b1, q);
            chk(q == 0 && !req_valid, "R1 rejected write", q, 0);
        end
        do_write(mk(1'b0, 1'b1, 1'b0, 1'b0, 64'h0), 8'hFF, 1'b1);
        do_read(8'h7F, 1'b1, q);
        chk(q == 0, "R1 partial read zero", q, 0);
        do_read(8'hFF, 1'b0, q);
        chk(q == 0, "R1 unprivileged read zero", q, 0);
        do_read(8'hFF, 1'b1, q);
        chk(q == img(2), "R1 R2 full read", q, img(2));

        // Reset while pending
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(8'hFF, 1'b1, q);
        chk(q == 0 && !req_valid, "R9 reset clears pending", q, 0);

        finish_report();
    end
endmodule